// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A host offers a character on a valid/ready handshake. The frame shape is set by configuration inputs, which are captured when the character is accepted:

- number of data bits
- parity style, including an address/data marker for multidrop buses
- stop duration
- bit order
- count of idle guard bit times placed after each character

Timing comes from an external oversampling tick. The block divides that tick down to half-bit steps, which lets it produce a one-and-a-half bit stop period exactly.

Flow control is an active-low clear-to-send input. When handshaking is enabled and clear-to-send is deasserted, no new character starts. A break request drives the line low for longer than any legal frame and then releases it to the idle level.

Top module: `tx_async`

## Requirements
- R1: While no character or break is in progress, `txd` is high (idle). `in_ready` is high only when idle, no break is requested, and flow control allows a start.
- R2: An accepted character (`in_valid && in_ready` at a clock edge) produces the following sequence on `txd`: a low start bit, then the data bits, then the optional parity slot, then a high stop period. With `cfg_msb_first`=0, data goes least significant bit first.
- R3: `cfg_len` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Only `in_data[len-1:0]` is sent.
- R4: `cfg_parity` chooses the parity slot: 0 none, 1 even (bit equals XOR of the data bits), 2 odd (its inverse), 3 constant 0, 4 constant 1, 5 multidrop, 6 and 7 none.
- R5: In multidrop mode (`cfg_parity`=5) the parity slot carries `cfg_addr`, which is 1 for an address character and 0 for data.
- R6: With `cfg_msb_first`=1 the data bits go out from bit len-1 down to bit 0.
- R7: One bit time equals OSR `os_tick` pulses. `cfg_stop` selects the stop period: 0 gives 1 bit time, 1 gives 1.5 bit times, and 2 or 3 give 2 bit times. `txd` changes only at half-bit boundaries, except for the start of a frame.
- R8: After the stop period, `txd` stays high for `cfg_guard` further bit times. `in_ready` returns only after that.
- R9: When `cfg_cts_en`=1 and `cts_n`=1 while idle, `in_ready` stays low and no frame starts.
- R10: A `brk_req` seen while idle has priority over `in_valid`. The break drives `txd` low for the full frame length plus the stop period, then high for the stop period, then the guard time. `in_ready` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit time |
| in_data | input | 9 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be accepted this cycle |
| cfg_len | input | 4 | Data bit count, 5 to 9 |
| cfg_parity | input | 3 | Parity slot mode |
| cfg_stop | input | 2 | Stop period select |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_guard | input | 8 | Idle guard bit times after each character |
| cfg_addr | input | 1 | Address flag for multidrop mode |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| brk_req | input | 1 | Request a break condition |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame, break or guard in progress |

## Verification
A wrong bit-slot pointer or a corrupted shift register shows up on `txd` within the same frame. At the mid-bit sample of the affected slot, the line carries a wrong data, parity or stop level. A half-bit counter that is off by one moves every later edge by eight clocks. That drift is first seen as a wrong stop length, then as `in_ready` returning on the wrong clock. Because the whole frame timing is fixed at the accept edge, a mistake in the latched stop or guard settings appears only in how long the frame lasts. The bench therefore checks the exact clock on which `in_ready` returns, not just the bit values.

// File: rtl/tx_async_pkg.sv
package tx_async_pkg;

  localparam int MAX_LEN = 9;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4,
    PAR_ADDR = 3'd5
  } par_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GUARD = 2'd2
  } tx_state_t;

  function automatic logic [3:0] eff_len(input logic [3:0] l);
    if (l < 4'(MIN_LEN)) return 4'(MIN_LEN);
    if (l > 4'(MAX_LEN)) return 4'(MAX_LEN);
    return l;
  endfunction

  function automatic logic has_par(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction

  function automatic logic par_bit(input logic [MAX_LEN-1:0] d, input logic [3:0] len,
                                   input logic [2:0] m, input logic addr);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_LEN; i++)
      if (i < int'(len)) x ^= d[i];
    case (m)
      PAR_EVEN: return x;
      PAR_ODD:  return ~x;
      PAR_ONE:  return 1'b1;
      PAR_ADDR: return addr;
      default:  return 1'b0;
    endcase
  endfunction

  // stop period measured in half bit times
  function automatic logic [2:0] stop_halves(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [MAX_LEN-1:0] order_bits(input logic [MAX_LEN-1:0] d,
                                                    input logic [3:0] len, input logic msb);
    logic [MAX_LEN-1:0] o;
    o = '0;
    for (int i = 0; i < MAX_LEN; i++)
      if (i < int'(len)) o[i] = msb ? d[int'(len) - 1 - i] : d[i];
    return o;
  endfunction

endpackage

// File: rtl/tx_halfdiv.sv
module tx_halfdiv #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic sync_clr,
  output logic half_p
);
  localparam int HALF = OSR / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign half_p = os_tick && (cnt == CW'(HALF - 1)) && !sync_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (sync_clr)      cnt <= '0;
    else if (half_p)        cnt <= '0;
    else if (os_tick)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import tx_async_pkg::*;
#(
  parameter int FW = 12,
  parameter int HW = 6
) (
  input  logic [MAX_LEN-1:0] data,
  input  logic [3:0]         len_cfg,
  input  logic [2:0]         par_cfg,
  input  logic [1:0]         stop_cfg,
  input  logic               msb_first,
  input  logic               addr,
  output logic [FW-1:0]      frame,
  output logic [HW-1:0]      chr_halves,
  output logic [HW-1:0]      brk_halves,
  output logic [2:0]         stop_h
);
  logic [3:0]         len;
  logic               p_on;
  logic [MAX_LEN-1:0] ord;
  logic [HW-1:0]      body_h;

  always_comb begin
    len    = eff_len(len_cfg);
    p_on   = has_par(par_cfg);
    ord    = order_bits(data, len, msb_first);
    stop_h = stop_halves(stop_cfg);
    frame  = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_LEN; i++)
      if (i < int'(len)) frame[1+i] = ord[i];
    if (p_on) frame[1 + int'(len)] = par_bit(data, len, par_cfg, addr);
    body_h     = HW'(2 * (1 + int'(len) + int'(p_on)));
    chr_halves = body_h + HW'(stop_h);
    brk_halves = body_h + HW'(2 * int'(stop_h));
  end
endmodule

// File: rtl/tx_seq.sv
module tx_seq
  import tx_async_pkg::*;
#(
  parameter int FW = 12,
  parameter int HW = 6,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_p,
  input  logic          go_chr,
  input  logic          go_brk,
  input  logic [FW-1:0] frame,
  input  logic [HW-1:0] chr_halves,
  input  logic [HW-1:0] brk_halves,
  input  logic [2:0]    stop_h,
  input  logic [GW-1:0] guard,
  output logic          txd,
  output logic          busy
);
  tx_state_t     st;
  logic [FW-1:0] sr;
  logic [HW-1:0] rem;
  logic [GW:0]   grem;
  logic [GW-1:0] grd;
  logic [2:0]    sh;
  logic          phase, brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sr <= '1; rem <= '0; grem <= '0; grd <= '0;
      sh <= 3'd2; phase <= 1'b0; brk <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          phase <= 1'b0;
          grd   <= guard;
          sh    <= stop_h;
          if (go_brk) begin
            st <= ST_FRAME; brk <= 1'b1; rem <= brk_halves; sr <= '1;
          end else if (go_chr) begin
            st <= ST_FRAME; brk <= 1'b0; rem <= chr_halves; sr <= frame;
          end
        end
        ST_FRAME: if (half_p) begin
          if (rem == HW'(1)) begin
            sr   <= '1;
            brk  <= 1'b0;
            grem <= {grd, 1'b0};
            st   <= (grd == '0) ? ST_IDLE : ST_GUARD;
          end else begin
            rem   <= rem - 1'b1;
            phase <= ~phase;
            if (phase) sr <= {1'b1, sr[FW-1:1]};
          end
        end
        ST_GUARD: if (half_p) begin
          if (grem == (GW+1)'(1)) st <= ST_IDLE;
          else                    grem <= grem - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy = (st != ST_IDLE);
    if (st != ST_FRAME) txd = 1'b1;
    else if (brk)       txd = (rem <= HW'(sh));
    else                txd = sr[0];
  end
endmodule

// File: rtl/tx_async.sv
module tx_async
  import tx_async_pkg::*;
#(
  parameter int OSR = 16,
  parameter int GW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               os_tick,
  input  logic [MAX_LEN-1:0] in_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [3:0]         cfg_len,
  input  logic [2:0]         cfg_parity,
  input  logic [1:0]         cfg_stop,
  input  logic               cfg_msb_first,
  input  logic [GW-1:0]      cfg_guard,
  input  logic               cfg_addr,
  input  logic               cfg_cts_en,
  input  logic               cts_n,
  input  logic               brk_req,
  output logic               txd,
  output logic               busy
);
  localparam int FW = MAX_LEN + 3;
  localparam int HW = $clog2(2 * FW + 8) + 1;

  logic          cts_ok, go_chr, go_brk, half_p;
  logic [FW-1:0] frame;
  logic [HW-1:0] chr_halves, brk_halves;
  logic [2:0]    stop_h;

  assign cts_ok   = !cfg_cts_en || !cts_n;
  assign in_ready = !busy && !brk_req && cts_ok;
  assign go_chr   = in_valid && in_ready;
  assign go_brk   = !busy && brk_req;

  tx_halfdiv #(.OSR(OSR)) u_div (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .sync_clr(go_chr || go_brk), .half_p(half_p)
  );

  tx_framer #(.FW(FW), .HW(HW)) u_frm (
    .data(in_data), .len_cfg(cfg_len), .par_cfg(cfg_parity), .stop_cfg(cfg_stop),
    .msb_first(cfg_msb_first), .addr(cfg_addr), .frame(frame),
    .chr_halves(chr_halves), .brk_halves(brk_halves), .stop_h(stop_h)
  );

  tx_seq #(.FW(FW), .HW(HW), .GW(GW)) u_seq (
    .clk(clk), .rst_n(rst_n), .half_p(half_p), .go_chr(go_chr), .go_brk(go_brk),
    .frame(frame), .chr_halves(chr_halves), .brk_halves(brk_halves),
    .stop_h(stop_h), .guard(cfg_guard), .txd(txd), .busy(busy)
  );
endmodule

// File: rtl/tx_async_chk.sv
module tx_async_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic in_ready,
  input logic in_valid,
  input logic brk_req,
  input logic cfg_cts_en,
  input logic cts_n,
  input logic go_chr,
  input logic go_brk,
  input logic half_p
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    go_chr |=> !txd);

  a_r7_edges_on_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_p && !go_chr && !go_brk) |=> $stable(txd));

  a_r9_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cts_en && cts_n) |-> !in_ready);

  a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    go_brk |=> (!txd && busy));

  a_r10_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !in_ready);
endmodule

bind tx_async tx_async_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .busy(busy), .in_ready(in_ready),
  .in_valid(in_valid), .brk_req(brk_req), .cfg_cts_en(cfg_cts_en), .cts_n(cts_n),
  .go_chr(go_chr), .go_brk(go_brk), .half_p(half_p)
);

// File: tb/tx_async_bench.sv
module tx_async_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic [8:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] cfg_len = 4'd8;
  logic [2:0] cfg_parity = 3'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic       cfg_msb_first = 1'b0;
  logic [7:0] cfg_guard = 8'd0;
  logic       cfg_addr = 1'b0;
  logic       cfg_cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       brk_req = 1'b0;
  logic       txd, busy;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tx_async u_tx_async (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int elen(input int l);
    return (l < 5) ? 5 : (l > 9) ? 9 : l;
  endfunction
  function automatic int shalf(input int s);
    return (s == 0) ? 2 : (s == 1) ? 3 : 4;
  endfunction

  task automatic t_char(input string req, input logic [8:0] d, input int len, input int par,
                        input int stp, input bit msb, input int grd, input bit addr);
    int L, p, nb, sh, n, k, rdy_at;
    int exp_bits[12];
    int x;
    L = elen(len); p = (par >= 1 && par <= 5) ? 1 : 0; nb = 1 + L + p; sh = shalf(stp);
    x = 0;
    for (int i = 0; i < L; i++) x ^= d[i];
    exp_bits[0] = 0;
    for (int i = 0; i < L; i++) exp_bits[1+i] = msb ? d[L-1-i] : d[i];
    if (p == 1)
      exp_bits[1+L] = (par == 1) ? x : (par == 2) ? 1-x : (par == 3) ? 0 : (par == 4) ? 1 : int'(addr);
    n = 8 * (2*nb + sh + 2*grd);
    @(negedge clk);
    in_data = d; cfg_len = 4'(len); cfg_parity = 3'(par); cfg_stop = 2'(stp);
    cfg_msb_first = msb; cfg_guard = 8'(grd); cfg_addr = addr; in_valid = 1'b1;
    #1 check({req, " ready when idle (R1)"}, int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rdy_at = -1;
    for (k = 0; k < n + 40; k++) begin
      for (int i = 0; i < nb; i++)
        if (k == 8 + 16*i) check($sformatf("%s bit%0d (R2)", req, i), int'(txd), exp_bits[i]);
      if (k == 16*nb + 2*sh - 1) check({req, " stop high (R7)"}, int'(txd), 1);
      if (in_ready) begin rdy_at = k; break; end
      @(negedge clk);
    end
    check({req, " ready return cycle (R7 R8)"}, rdy_at, n);
  endtask

  task automatic t_cts();
    @(negedge clk);
    cfg_cts_en = 1'b1; cts_n = 1'b1; cfg_len = 4'd8; cfg_parity = 3'd0; in_valid = 1'b1;
    in_data = 9'h0AA;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 39) begin
        check("R9 ready held low", int'(in_ready), 0);
        check("R9 line idle", int'(txd), 1);
      end
    end
    in_valid = 1'b0; cts_n = 1'b0;
    #1 check("R9 ready after cts", int'(in_ready), 1);
    cfg_cts_en = 1'b0;
  endtask

  task automatic t_break(input int len, input int par, input int stp, input int grd);
    int L, p, nb, sh, low, n, k, rdy_at, ready_seen;
    L = elen(len); p = (par >= 1 && par <= 5) ? 1 : 0; nb = 1 + L + p; sh = shalf(stp);
    low = 8 * (2*nb + sh); n = 8 * (2*nb + 2*sh + 2*grd);
    @(negedge clk);
    cfg_len = 4'(len); cfg_parity = 3'(par); cfg_stop = 2'(stp); cfg_guard = 8'(grd);
    in_data = 9'h1FF; in_valid = 1'b1; brk_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brk_req = 1'b0; in_valid = 1'b0;
    rdy_at = -1; ready_seen = 0;
    for (k = 0; k < n + 40; k++) begin
      if (k == low - 1) check("R10 break still low", int'(txd), 0);
      if (k == low)     check("R10 break released", int'(txd), 1);
      if (in_ready) begin rdy_at = k; break; end
      @(negedge clk);
    end
    check("R10 break total length", rdy_at, n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset txd", int'(txd), 1);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    t_char("R2 lsb8", 9'h0A5, 8, 0, 0, 1'b0, 0, 1'b0);
    t_char("R3 len5", 9'h1F3, 5, 0, 0, 1'b0, 0, 1'b0);
    t_char("R3 len9", 9'h15A, 9, 1, 0, 1'b0, 0, 1'b0);
    t_char("R3 clamp", 9'h16C, 12, 0, 0, 1'b0, 0, 1'b0);
    t_char("R4 even", 9'h007, 8, 1, 0, 1'b0, 0, 1'b0);
    t_char("R4 odd", 9'h007, 8, 2, 0, 1'b0, 0, 1'b0);
    t_char("R4 zero", 9'h0FF, 7, 3, 0, 1'b0, 0, 1'b0);
    t_char("R4 one", 9'h000, 6, 4, 0, 1'b0, 0, 1'b0);
    t_char("R4 none7", 9'h055, 8, 7, 0, 1'b0, 0, 1'b0);
    t_char("R5 addr", 9'h031, 8, 5, 0, 1'b0, 0, 1'b1);
    t_char("R5 data", 9'h031, 8, 5, 0, 1'b0, 0, 1'b0);
    t_char("R6 msb", 9'h0C1, 8, 0, 0, 1'b1, 0, 1'b0);
    t_char("R6 msb9", 9'h103, 9, 2, 1, 1'b1, 0, 1'b0);
    t_char("R7 stop1.5", 9'h03C, 7, 0, 1, 1'b0, 0, 1'b0);
    t_char("R7 stop2", 9'h03C, 7, 1, 2, 1'b0, 0, 1'b0);
    t_char("R8 guard3", 9'h081, 8, 0, 0, 1'b0, 3, 1'b0);
    t_char("R8 guard1 st1.5", 9'h011, 5, 2, 1, 1'b0, 1, 1'b0);
    t_cts();
    t_char("R9 after cts", 9'h0E7, 8, 0, 0, 1'b0, 0, 1'b0);
    t_break(8, 0, 0, 0);
    t_break(9, 1, 1, 2);
    t_char("R10 after break", 9'h05A, 8, 1, 0, 1'b0, 0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule